// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block gives one processor port atomic read-modify-write semantics on a small shared word memory, and lets a second master write the same memory. A linked load returns a word and arms a single reservation on that word. A later conditional store to the same word writes only while the reservation is still armed. It answers 1 when the write happened and 0 when it was suppressed. Software loops on the linked-load / conditional-store pair until it gets a 1, and so builds an atomic exchange or a test-and-set lock.

The reservation is cleared by any write to the reserved word, whichever side makes it. It is also cleared by every conditional store, whatever the outcome, and by reset. Addresses are byte addresses of aligned words. The two low bits take no part in word selection or in the reservation compare. Each processor request produces one response one cycle later. Both write ports commit on the clock edge of the request.

Top module: `llsc_monitor`

## Requirements
- R1: During and after reset no reservation is held, every memory word reads 0, and `rsp_valid` is 0. A conditional store issued before any linked load answers 0 and leaves memory unchanged.
- R2: `cpu_op` encodes 2'b00 plain load, 2'b01 plain store, 2'b10 linked load and 2'b11 conditional store. When `cpu_req` is high, `rsp_valid` is high in the next cycle; otherwise it is low in the next cycle. A load or linked load answers the word as it was before that edge. A plain store writes at the edge and answers 0.
- R3: A linked load arms a reservation on its word. A conditional store to that word with no intervening write to it answers 1 (bit 0 set, all other bits 0) and writes its data.
- R4: A write by the other master to the reserved word, made after the linked load and before the conditional store, makes the conditional store answer 0 and leaves the other master's data in memory.
- R5: Writes by the other master to words other than the reserved one leave the reservation armed.
- R6: A conditional store to a word other than the reserved one answers 0, does not write, and clears the reservation.
- R7: Every conditional store clears the reservation, so a second conditional store with no new linked load answers 0.
- R8: Word selection and reservation matching ignore address bits [1:0].
- R9: A conditional store and a write by the other master to the same word in the same cycle: the conditional store answers 0 and the other master's data is stored.
- R10: A linked load and a write by the other master to the same word in the same cycle: the load answers the old word and no reservation is armed.
- R11: A plain store by the processor to the reserved word clears the reservation.
- R12: A plain processor store and a write by the other master to the same word in the same cycle leave the other master's data in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request strobe |
| cpu_op | input | 2 | Request kind (see R2) |
| cpu_addr | input | AW (6) | Processor byte address |
| cpu_wdata | input | DW (32) | Processor store data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_data | output | DW (32) | Read word, or conditional-store flag, or 0 |
| ext_we | input | 1 | Other master write strobe |
| ext_addr | input | AW (6) | Other master byte address |
| ext_wdata | input | DW (32) | Other master write data |

## Verification
The key collision is a processor request and a write by the other master landing on the same word in the same cycle. This covers a conditional store racing an outside write (R9), a linked load racing one (R10), and a plain store racing one (R12). Directed steps force each of these races. The random phase also keeps both masters on four words so that such races recur often. The bench judges each race by the conditional-store flag, by a later conditional store that shows whether a reservation survived, and by reading the word back to see whose data won.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_LINK  = 2'b10,
        OP_COND  = 2'b11
    } mem_op_e;

    typedef enum logic [1:0] {
        RK_READ = 2'b00,
        RK_ZERO = 2'b01,
        RK_FLAG = 2'b10
    } rsp_kind_e;

    function automatic rsp_kind_e kind_of(mem_op_e op);
        case (op)
            OP_LOAD, OP_LINK: return RK_READ;
            OP_COND:          return RK_FLAG;
            default:          return RK_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/llsc_resv_tracker.sv
module llsc_resv_tracker #(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          link_en,
    input  logic          cond_en,
    input  logic          store_en,
    input  logic [IW-1:0] cpu_widx,
    input  logic          ext_we,
    input  logic [IW-1:0] ext_widx,
    output logic          cond_ok
);

    typedef struct packed {
        logic          armed;
        logic [IW-1:0] idx;
    } resv_t;

    resv_t resv_q, resv_d;
    logic  ext_same_word;
    logic  ext_hits_resv;
    logic  cpu_hits_resv;

    assign ext_same_word = ext_we && (ext_widx == cpu_widx);
    assign ext_hits_resv = ext_we && (ext_widx == resv_q.idx);
    assign cpu_hits_resv = store_en && (cpu_widx == resv_q.idx);
    assign cond_ok       = cond_en && resv_q.armed &&
                           (resv_q.idx == cpu_widx) && !ext_same_word;

    always_comb begin
        resv_d = resv_q;
        if (link_en) begin
            resv_d.armed = !ext_same_word;
            resv_d.idx   = cpu_widx;
        end else if (cond_en) begin
            resv_d.armed = 1'b0;
        end else if (ext_hits_resv || cpu_hits_resv) begin
            resv_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) resv_q <= '0;
        else     resv_q <= resv_d;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> !resv_q.armed);

    a_r3_link_arms: assert property (@(posedge clk) disable iff (rst)
        (link_en && !ext_same_word) |=> (resv_q.armed && resv_q.idx == $past(cpu_widx)));

    a_r4_ext_write_disarms: assert property (@(posedge clk) disable iff (rst)
        (ext_hits_resv && !link_en) |=> !resv_q.armed);

    a_r7_cond_disarms: assert property (@(posedge clk) disable iff (rst)
        cond_en |=> !resv_q.armed);

    a_r9_race_fails: assert property (@(posedge clk) disable iff (rst)
        (cond_en && ext_same_word) |-> !cond_ok);

    a_r10_race_no_arm: assert property (@(posedge clk) disable iff (rst)
        (link_en && ext_same_word) |=> !resv_q.armed);

endmodule

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_we,
    input  logic [IW-1:0] cpu_idx,
    input  logic [DW-1:0] cpu_data,
    input  logic          ext_we,
    input  logic [IW-1:0] ext_idx,
    input  logic [DW-1:0] ext_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_q
);

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else begin
            rd_q <= words[rd_idx];
            for (int i = 0; i < DEPTH; i++) begin
                if (ext_we && ext_idx == IW'(i))
                    words[i] <= ext_data;
                else if (cpu_we && cpu_idx == IW'(i))
                    words[i] <= cpu_data;
            end
        end
    end

    a_r12_ext_wins: assert property (@(posedge clk) disable iff (rst)
        (ext_we && cpu_we && ext_idx == cpu_idx)
        |=> (words[$past(ext_idx)] == $past(ext_data)));

endmodule

// File: rtl/llsc_rsp_stage.sv
module llsc_rsp_stage
    import llsc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  rsp_kind_e     kind,
    input  logic          flag,
    input  logic [DW-1:0] rd_q,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data
);

    rsp_kind_e kind_q;
    logic      flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            kind_q    <= RK_ZERO;
            flag_q    <= 1'b0;
        end else begin
            rsp_valid <= req;
            kind_q    <= kind;
            flag_q    <= flag;
        end
    end

    always_comb begin
        case (kind_q)
            RK_READ: rsp_data = rd_q;
            RK_FLAG: rsp_data = {{(DW-1){1'b0}}, flag_q};
            default: rsp_data = '0;
        endcase
    end

    a_r2_flag_is_bit: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && kind_q == RK_FLAG) |-> ($countones(rsp_data) <= 1));

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int  DW    = 32,
    parameter int  DEPTH = 16,
    localparam int IW    = $clog2(DEPTH),
    localparam int AW    = IW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic [1:0]    cpu_op,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    input  logic          ext_we,
    input  logic [AW-1:0] ext_addr,
    input  logic [DW-1:0] ext_wdata
);

    mem_op_e       op;
    logic [IW-1:0] cpu_widx;
    logic [IW-1:0] ext_widx;
    logic          link_en, cond_en, store_en, cond_ok, cpu_we;
    logic [DW-1:0] rd_q;
    logic [3:0]    unused_lo;

    assign op        = mem_op_e'(cpu_op);
    assign cpu_widx  = cpu_addr[AW-1:2];
    assign ext_widx  = ext_addr[AW-1:2];
    assign unused_lo = {cpu_addr[1:0], ext_addr[1:0]};
    assign link_en   = cpu_req && op == OP_LINK;
    assign cond_en   = cpu_req && op == OP_COND;
    assign store_en  = cpu_req && op == OP_STORE;
    assign cpu_we    = store_en || cond_ok;

    llsc_resv_tracker #(.IW(IW)) u_resv (
        .clk      (clk),
        .rst      (rst),
        .link_en  (link_en),
        .cond_en  (cond_en),
        .store_en (store_en),
        .cpu_widx (cpu_widx),
        .ext_we   (ext_we),
        .ext_widx (ext_widx),
        .cond_ok  (cond_ok)
    );

    llsc_word_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .cpu_we   (cpu_we),
        .cpu_idx  (cpu_widx),
        .cpu_data (cpu_wdata),
        .ext_we   (ext_we),
        .ext_idx  (ext_widx),
        .ext_data (ext_wdata),
        .rd_idx   (cpu_widx),
        .rd_q     (rd_q)
    );

    llsc_rsp_stage #(.DW(DW)) u_rsp (
        .clk       (clk),
        .rst       (rst),
        .req       (cpu_req),
        .kind      (kind_of(op)),
        .flag      (cond_ok),
        .rd_q      (rd_q),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    a_r6_mismatch_no_write: assert property (@(posedge clk) disable iff (rst)
        (cond_en && !cond_ok) |-> !cpu_we);

endmodule

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;

    localparam int DW = 32;
    localparam int DEPTH = 16;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0;
    logic [1:0]    cpu_op = 2'b00;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          ext_we = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [DW-1:0] ext_wdata = '0;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    logic          ref_armed;
    logic [3:0]    ref_idx;

    always #5 clk = ~clk;

    llsc_monitor #(.DW(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_op(cpu_op),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] expect_rsp(input logic [1:0] op, input logic [3:0] idx,
                                                 input logic ehit);
        if (op == 2'b00 || op == 2'b10) return ref_mem[idx];
        if (op == 2'b11) return {31'd0, ref_armed && ref_idx == idx && !ehit};
        return '0;
    endfunction

    // One cycle: drive both ports, update the reference from the requirements, check response
    task automatic step(input logic rq, input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input logic ew, input logic [AW-1:0] ea,
                        input logic [DW-1:0] ed, input string req);
        logic [3:0]    idx  = a[5:2];
        logic [3:0]    eidx = ea[5:2];
        logic          ehit = ew && eidx == idx;
        logic [DW-1:0] exp  = expect_rsp(op, idx, ehit);
        logic          wr   = rq && (op == 2'b01 || (op == 2'b11 && exp[0]));
        if (wr) ref_mem[idx] = wd;
        if (ew) ref_mem[eidx] = ed;
        if (rq && op == 2'b10) begin
            ref_armed = !ehit;
            ref_idx   = idx;
        end else if (rq && op == 2'b11) begin
            ref_armed = 1'b0;
        end else if ((ew && eidx == ref_idx) || (rq && op == 2'b01 && idx == ref_idx)) begin
            ref_armed = 1'b0;
        end
        cpu_req = rq; cpu_op = op; cpu_addr = a; cpu_wdata = wd;
        ext_we = ew; ext_addr = ea; ext_wdata = ed;
        @(posedge clk);
        #1;
        cpu_req = 1'b0; ext_we = 1'b0;
        chk(rsp_valid == rq, {req, " valid"}, {31'd0, rsp_valid}, {31'd0, rq});
        if (rq) chk(rsp_data == exp, {req, " data"}, rsp_data, exp);
    endtask

    task automatic cpu(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       input string req);
        step(1'b1, op, a, wd, 1'b0, '0, '0, req);
    endtask

    task automatic ext(input logic [AW-1:0] ea, input logic [DW-1:0] ed, input string req);
        step(1'b0, 2'b00, '0, '0, 1'b1, ea, ed, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired (R2 responses stalled)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        ref_armed = 1'b0;
        ref_idx   = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(rsp_valid == 1'b0, "R1 valid in reset", {31'd0, rsp_valid}, 32'd0);
        rst = 1'b0;
        // R1: memory cleared, no reservation after reset
        cpu(2'b00, 6'h04, '0, "R1 read after reset");
        cpu(2'b11, 6'h08, 32'hDEAD0001, "R1 cond before link");
        cpu(2'b00, 6'h08, '0, "R1 no write from failed cond");
        // R2: plain store and load
        cpu(2'b01, 6'h10, 32'h1234_5678, "R2 store");
        cpu(2'b00, 6'h10, '0, "R2 load");
        step(1'b0, 2'b00, '0, '0, 1'b0, '0, '0, "R2 idle");
        // R3: uncontended swap
        cpu(2'b10, 6'h10, '0, "R3 link");
        cpu(2'b11, 6'h10, 32'hAAAA_0003, "R3 cond success");
        cpu(2'b00, 6'h10, '0, "R3 written");
        // R7: second cond without link fails
        cpu(2'b11, 6'h10, 32'hBBBB_0007, "R7 second cond");
        cpu(2'b00, 6'h10, '0, "R7 no write");
        // R4: interfering outside write
        cpu(2'b10, 6'h14, '0, "R4 link");
        ext(6'h14, 32'hE4E4_E4E4, "R4 ext write");
        cpu(2'b11, 6'h14, 32'h0000_0404, "R4 cond fails");
        cpu(2'b00, 6'h14, '0, "R4 ext data kept");
        // R5: outside write elsewhere
        cpu(2'b10, 6'h18, '0, "R5 link");
        ext(6'h1C, 32'h5555_5555, "R5 ext other word");
        cpu(2'b11, 6'h18, 32'h0505_0505, "R5 cond success");
        // R6: address mismatch
        cpu(2'b10, 6'h20, '0, "R6 link");
        cpu(2'b11, 6'h24, 32'h0606_0606, "R6 cond wrong word");
        cpu(2'b00, 6'h24, '0, "R6 no write");
        cpu(2'b11, 6'h20, 32'h0606_0607, "R6 reservation cleared");
        // R8: low address bits ignored
        cpu(2'b10, 6'h28, '0, "R8 link");
        cpu(2'b11, 6'h2B, 32'h0808_0808, "R8 cond low bits differ");
        cpu(2'b10, 6'h29, '0, "R8 link offset");
        ext(6'h2A, 32'h8888_0000, "R8 ext low bits differ");
        cpu(2'b11, 6'h28, 32'h0808_0809, "R8 cond fails");
        // R9: same-cycle cond and outside write
        cpu(2'b10, 6'h30, '0, "R9 link");
        step(1'b1, 2'b11, 6'h30, 32'h0909_0909, 1'b1, 6'h31, 32'h9999_9999, "R9 race cond");
        cpu(2'b00, 6'h30, '0, "R9 ext data");
        // R10: same-cycle link and outside write
        step(1'b1, 2'b10, 6'h34, '0, 1'b1, 6'h34, 32'hAAAA_1010, "R10 race link");
        cpu(2'b11, 6'h34, 32'h1010_1010, "R10 no reservation");
        cpu(2'b00, 6'h34, '0, "R10 ext data");
        // R11: own plain store clears
        cpu(2'b10, 6'h38, '0, "R11 link");
        cpu(2'b01, 6'h38, 32'h1111_0000, "R11 store");
        cpu(2'b11, 6'h38, 32'h1111_1111, "R11 cond fails");
        // R12: same-cycle plain store and outside write
        step(1'b1, 2'b01, 6'h3C, 32'h1212_0000, 1'b1, 6'h3C, 32'hCCCC_1212, "R12 race store");
        cpu(2'b00, 6'h3C, '0, "R12 ext data");
        // Random phase: both masters on four words (R2 R3 R4 R9 R10 R11 R12)
        void'($urandom(32'd1234));
        for (int n = 0; n < 600; n++) begin
            logic          rq = ($urandom % 4) != 0;
            logic [1:0]    op = 2'($urandom);
            logic [AW-1:0] a  = {2'b01, 2'($urandom), 2'($urandom)};
            logic          ew = ($urandom % 3) == 0;
            logic [AW-1:0] ea = {2'b01, 2'($urandom), 2'($urandom)};
            step(rq, op, a, $urandom, ew, ea, $urandom, "R3 random mix");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule